// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block stores sixty-four 32-bit single-precision values. It also owns the two control words that decide how those values are addressed. One is a 32-bit mode register that holds six individually writable mode bits. The other is a 32-bit floating-point status word. One of the mode bits is the bank bit. It splits the array into a current half and an opposite half of sixteen entries each, so a bank-relative index lands on a different physical entry depending on that bit. A 3-bit view code on each access picks how the index is turned into a physical entry:

- raw
- current bank
- opposite bank
- a double-width pair (raw, current bank or opposite bank)
- a strided vector slot
- a strided matrix slot

The block has one write port and one read port for the array. Reads are combinational from the stored state. Writes land on the next clock edge. A separate combined control port returns the status word with three mode bits merged into it. Writing that port updates both the status word and those three mode bits. Arithmetic and rounding belong to other blocks.

Top module: `fpr_bank_file`

## Requirements
- R1: While reset is low, and after it is released, every array entry, the status word and the mode register are all zero.
- R2: View codes are 0 raw, 1 current bank, 2 opposite bank, 3 pair, 4 pair in current bank, 5 pair in opposite bank, 6 vector, 7 matrix. A write lands on the next rising edge, so a read of the same entry in the write cycle returns the old value. Single views (0, 1, 2, 6, 7) write `wr_data[31:0]` and return the entry in `rd_data[31:0]` with `rd_data[63:32]` zero.
- R3: A current-bank access uses physical index (16·bank + idx) mod 64. An opposite-bank access uses (16·(1−bank) + idx) mod 64.
- R4: A pair access with base b uses entry b for bits 63:32 and entry (b+1) mod 64 for bits 31:0, on both read and write. The base b is idx for code 3, the current-bank index for code 4 and the opposite-bank index for code 5.
- R5: A vector access uses entry 4·(idx mod 16). A matrix access uses entry 16·(idx mod 4).
- R6: The mode register holds S at bit 1, Q at bit 8, M at bit 9, PR at bit 12, SZ at bit 13 and the bank bit at bit 14. A mode-bit write with select codes 0..5 (S, Q, M, PR, SZ, bank, in that order) sets only the selected bit to `mb_val`. Select codes 6 and 7 change nothing. All other register bits stay zero.
- R7: `cw_rdata` is the status word ORed with PR at bit 19, SZ at bit 20 and the bank bit at bit 21.
- R8: A combined-port write stores all 32 bits into the status word and copies bits 19, 20 and 21 into PR, SZ and the bank bit. For those three bits it overrides a mode-bit write made in the same cycle.
- R9: A change of the bank bit affects bank-relative accesses from the cycle after the write. An array write made in the same cycle as the bank change still uses the old bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Array write enable |
| wr_view | input | 3 | View code of the write |
| wr_idx | input | 6 | Logical index of the write |
| wr_data | input | 64 | Write data; a single view uses bits 31:0 |
| rd_view | input | 3 | View code of the read |
| rd_idx | input | 6 | Logical index of the read |
| rd_data | output | 64 | Read data |
| mb_we | input | 1 | Mode-bit write enable |
| mb_sel | input | 3 | Mode-bit select code |
| mb_val | input | 1 | New value of the selected mode bit |
| cw_we | input | 1 | Combined control word write enable |
| cw_wdata | input | 32 | Combined control word write data |
| cw_rdata | output | 32 | Combined control word read data |
| sr_rdata | output | 32 | Mode register contents |

## Verification
The bench uses the default parameters: 64 entries, banks of 16, vector stride 4 over a 4-bit index mask, and matrix stride 16 over a 2-bit mask. With these values, an opposite-bank index of 50 folds back past the end of the array to entry 2. A pair based at entry 63 places its low half in entry 0. A vector index of 19 loses its upper bits and selects entry 12. The bank bit is toggled between table runs, so the same logical index is shown landing on both halves of the array.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        VW_RAW      = 3'd0,
        VW_CUR      = 3'd1,
        VW_OPP      = 3'd2,
        VW_PAIR     = 3'd3,
        VW_PAIR_CUR = 3'd4,
        VW_PAIR_OPP = 3'd5,
        VW_VEC      = 3'd6,
        VW_MTX      = 3'd7
    } view_e;

    typedef enum logic [2:0] {
        MB_S    = 3'd0,
        MB_Q    = 3'd1,
        MB_M    = 3'd2,
        MB_PR   = 3'd3,
        MB_SZ   = 3'd4,
        MB_BANK = 3'd5,
        MB_RSV6 = 3'd6,
        MB_RSV7 = 3'd7
    } mode_bit_e;

    localparam int SR_W = 32;
    localparam int CW_W = 32;

    // mode register bit positions (decoded by neighbouring units)
    localparam int SR_S_POS    = 1;
    localparam int SR_Q_POS    = 8;
    localparam int SR_M_POS    = 9;
    localparam int SR_PR_POS   = 12;
    localparam int SR_SZ_POS   = 13;
    localparam int SR_BANK_POS = 14;

    // merged positions inside the combined control word
    localparam int CW_PR_POS   = 19;
    localparam int CW_SZ_POS   = 20;
    localparam int CW_BANK_POS = 21;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [CW_W-1:0] fpsw;
    } mode_state_t;

endpackage

// File: rtl/fpr_index_map.sv
module fpr_index_map
    import fpr_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int BANK_SZ    = 16,
    parameter int VEC_MASK_W = 4,
    parameter int VEC_STRIDE = 4,
    parameter int MTX_MASK_W = 2,
    parameter int MTX_STRIDE = 16,
    parameter int IDX_W      = $clog2(ENTRIES)
) (
    input  view_e             view,
    input  logic [IDX_W-1:0]  idx,
    input  logic              bank,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [IDX_W-1:0]  lo_idx,
    output logic              is_pair
);

    localparam logic [IDX_W-1:0] BANK_K = IDX_W'(BANK_SZ);
    localparam logic [IDX_W-1:0] VEC_K  = IDX_W'(VEC_STRIDE);
    localparam logic [IDX_W-1:0] MTX_K  = IDX_W'(MTX_STRIDE);
    localparam logic [IDX_W-1:0] ONE    = IDX_W'(1);

    logic [IDX_W-1:0] off_cur;
    logic [IDX_W-1:0] off_opp;
    logic [IDX_W-1:0] base;

    always_comb begin
        off_cur = bank ? BANK_K : '0;
        off_opp = bank ? '0 : BANK_K;
        is_pair = 1'b0;
        unique case (view)
            VW_RAW:      base = idx;
            VW_CUR:      base = idx + off_cur;
            VW_OPP:      base = idx + off_opp;
            VW_PAIR:     begin base = idx;           is_pair = 1'b1; end
            VW_PAIR_CUR: begin base = idx + off_cur; is_pair = 1'b1; end
            VW_PAIR_OPP: begin base = idx + off_opp; is_pair = 1'b1; end
            VW_VEC:      base = IDX_W'(idx[VEC_MASK_W-1:0]) * VEC_K;
            VW_MTX:      base = IDX_W'(idx[MTX_MASK_W-1:0]) * MTX_K;
            default:     base = idx;
        endcase
        hi_idx = base;
        lo_idx = base + ONE;
    end

endmodule

// File: rtl/fpr_mode_regs.sv
module fpr_mode_regs
    import fpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mb_we,
    input  mode_bit_e       mb_sel,
    input  logic            mb_val,
    input  logic            cw_we,
    input  logic [CW_W-1:0] cw_wdata,
    output logic [CW_W-1:0] cw_rdata,
    output logic [SR_W-1:0] sr_q_o,
    output logic            bank_o
);

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mb_we) begin
            unique case (mb_sel)
                MB_S:    st_d.sr[SR_S_POS]    = mb_val;
                MB_Q:    st_d.sr[SR_Q_POS]    = mb_val;
                MB_M:    st_d.sr[SR_M_POS]    = mb_val;
                MB_PR:   st_d.sr[SR_PR_POS]   = mb_val;
                MB_SZ:   st_d.sr[SR_SZ_POS]   = mb_val;
                MB_BANK: st_d.sr[SR_BANK_POS] = mb_val;
                default: ;
            endcase
        end
        // combined port is applied last so it wins on the shared bits
        if (cw_we) begin
            st_d.fpsw             = cw_wdata;
            st_d.sr[SR_PR_POS]    = cw_wdata[CW_PR_POS];
            st_d.sr[SR_SZ_POS]    = cw_wdata[CW_SZ_POS];
            st_d.sr[SR_BANK_POS]  = cw_wdata[CW_BANK_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cw_rdata              = st_q.fpsw;
        cw_rdata[CW_PR_POS]   = st_q.fpsw[CW_PR_POS]   | st_q.sr[SR_PR_POS];
        cw_rdata[CW_SZ_POS]   = st_q.fpsw[CW_SZ_POS]   | st_q.sr[SR_SZ_POS];
        cw_rdata[CW_BANK_POS] = st_q.fpsw[CW_BANK_POS] | st_q.sr[SR_BANK_POS];
    end

    assign sr_q_o = st_q.sr;
    assign bank_o = st_q.sr[SR_BANK_POS];

endmodule

// File: rtl/fpr_storage.sv
module fpr_storage #(
    parameter int ENTRIES = 64,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [IDX_W-1:0]  widx_hi,
    input  logic [IDX_W-1:0]  widx_lo,
    input  logic [DATA_W-1:0] wdata_hi,
    input  logic [DATA_W-1:0] wdata_lo,
    input  logic [IDX_W-1:0]  ridx_hi,
    input  logic [IDX_W-1:0]  ridx_lo,
    output logic [DATA_W-1:0] rdata_hi,
    output logic [DATA_W-1:0] rdata_lo
);

    typedef struct {
        logic [DATA_W-1:0] ent [ENTRIES];
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_hi) st_d.ent[widx_hi] = wdata_hi;
        if (we_lo) st_d.ent[widx_lo] = wdata_lo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ent: '{default: '0}};
        else        st_q <= st_d;
    end

    assign rdata_hi = st_q.ent[ridx_hi];
    assign rdata_lo = st_q.ent[ridx_lo];

endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file
    import fpr_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int DATA_W     = 32,
    parameter int BANK_SZ    = 16,
    parameter int VEC_MASK_W = 4,
    parameter int VEC_STRIDE = 4,
    parameter int MTX_MASK_W = 2,
    parameter int MTX_STRIDE = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [2:0]                   wr_view,
    input  logic [$clog2(ENTRIES)-1:0]   wr_idx,
    input  logic [2*DATA_W-1:0]          wr_data,
    input  logic [2:0]                   rd_view,
    input  logic [$clog2(ENTRIES)-1:0]   rd_idx,
    output logic [2*DATA_W-1:0]          rd_data,
    input  logic                         mb_we,
    input  logic [2:0]                   mb_sel,
    input  logic                         mb_val,
    input  logic                         cw_we,
    input  logic [CW_W-1:0]              cw_wdata,
    output logic [CW_W-1:0]              cw_rdata,
    output logic [SR_W-1:0]              sr_rdata
);

    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int N_PORTS = 2;   // 0: write side, 1: read side

    logic               bank;
    view_e              pv_view [N_PORTS];
    logic [IDX_W-1:0]   pv_idx  [N_PORTS];
    logic [IDX_W-1:0]   pv_hi   [N_PORTS];
    logic [IDX_W-1:0]   pv_lo   [N_PORTS];
    logic               pv_pair [N_PORTS];
    logic [DATA_W-1:0]  rd_hi, rd_lo;

    assign pv_view[0] = view_e'(wr_view);
    assign pv_idx[0]  = wr_idx;
    assign pv_view[1] = view_e'(rd_view);
    assign pv_idx[1]  = rd_idx;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_map
        fpr_index_map #(
            .ENTRIES    (ENTRIES),
            .BANK_SZ    (BANK_SZ),
            .VEC_MASK_W (VEC_MASK_W),
            .VEC_STRIDE (VEC_STRIDE),
            .MTX_MASK_W (MTX_MASK_W),
            .MTX_STRIDE (MTX_STRIDE),
            .IDX_W      (IDX_W)
        ) i_map (
            .view    (pv_view[p]),
            .idx     (pv_idx[p]),
            .bank    (bank),
            .hi_idx  (pv_hi[p]),
            .lo_idx  (pv_lo[p]),
            .is_pair (pv_pair[p])
        );
    end

    fpr_mode_regs i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mb_we    (mb_we),
        .mb_sel   (mode_bit_e'(mb_sel)),
        .mb_val   (mb_val),
        .cw_we    (cw_we),
        .cw_wdata (cw_wdata),
        .cw_rdata (cw_rdata),
        .sr_q_o   (sr_rdata),
        .bank_o   (bank)
    );

    fpr_storage #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_hi    (wr_en),
        .we_lo    (wr_en & pv_pair[0]),
        .widx_hi  (pv_hi[0]),
        .widx_lo  (pv_lo[0]),
        .wdata_hi (pv_pair[0] ? wr_data[2*DATA_W-1:DATA_W] : wr_data[DATA_W-1:0]),
        .wdata_lo (wr_data[DATA_W-1:0]),
        .ridx_hi  (pv_hi[1]),
        .ridx_lo  (pv_lo[1]),
        .rdata_hi (rd_hi),
        .rdata_lo (rd_lo)
    );

    assign rd_data = pv_pair[1] ? {rd_hi, rd_lo} : {{DATA_W{1'b0}}, rd_hi};

endmodule

// File: rtl/fpr_bank_file_chk.sv
module fpr_bank_file_chk
    import fpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mb_we,
    input logic [2:0]           mb_sel,
    input logic                 mb_val,
    input logic                 cw_we,
    input logic [CW_W-1:0]      cw_wdata,
    input logic [CW_W-1:0]      cw_rdata,
    input logic [SR_W-1:0]      sr_rdata,
    input logic [2:0]           rd_view,
    input logic [2*DATA_W-1:0]  rd_data
);

    localparam logic [SR_W-1:0] MODE_MASK =
        (SR_W'(1) << SR_S_POS)  | (SR_W'(1) << SR_Q_POS)  | (SR_W'(1) << SR_M_POS) |
        (SR_W'(1) << SR_PR_POS) | (SR_W'(1) << SR_SZ_POS) | (SR_W'(1) << SR_BANK_POS);

    logic [SR_W-1:0] sel_mask;
    logic            single_view;

    always_comb begin
        unique case (mb_sel)
            3'd0:    sel_mask = SR_W'(1) << SR_S_POS;
            3'd1:    sel_mask = SR_W'(1) << SR_Q_POS;
            3'd2:    sel_mask = SR_W'(1) << SR_M_POS;
            3'd3:    sel_mask = SR_W'(1) << SR_PR_POS;
            3'd4:    sel_mask = SR_W'(1) << SR_SZ_POS;
            3'd5:    sel_mask = SR_W'(1) << SR_BANK_POS;
            default: sel_mask = '0;
        endcase
        single_view = (rd_view < 3'd3) || (rd_view > 3'd5);
    end

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata & ~MODE_MASK) == '0);

    // R6
    bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_we && mb_sel < 3'd6 && (mb_sel < 3'd3 || !cw_we))
        |=> (((sr_rdata & $past(sel_mask)) != '0) == $past(mb_val)));

    // R6
    others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_we && !cw_we)
        |=> ((sr_rdata & ~$past(sel_mask)) == ($past(sr_rdata) & ~$past(sel_mask))));

    // R8
    cw_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_we |=> (cw_rdata == $past(cw_wdata)));

    // R8
    cw_to_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_we |=> (sr_rdata[SR_BANK_POS] == $past(cw_wdata[CW_BANK_POS]) &&
                   sr_rdata[SR_PR_POS]   == $past(cw_wdata[CW_PR_POS])));

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb_we && !cw_we) |=> ($stable(sr_rdata) && $stable(cw_rdata)));

    // R7
    bank_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rdata[SR_BANK_POS] |-> cw_rdata[CW_BANK_POS]);

    // R2
    single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        single_view |-> (rd_data[2*DATA_W-1:DATA_W] == '0));

endmodule

bind fpr_bank_file fpr_bank_file_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mb_we    (mb_we),
    .mb_sel   (mb_sel),
    .mb_val   (mb_val),
    .cw_we    (cw_we),
    .cw_wdata (cw_wdata),
    .cw_rdata (cw_rdata),
    .sr_rdata (sr_rdata),
    .rd_view  (rd_view),
    .rd_data  (rd_data)
);

// File: tb/test_fpr_bank_file.sv
`timescale 1ns/1ps
module test_fpr_bank_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_view = '0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_view = '0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        mb_we = 1'b0;
    logic [2:0]  mb_sel = '0;
    logic        mb_val = 1'b0;
    logic        cw_we = 1'b0;
    logic [31:0] cw_wdata = '0;
    logic [31:0] cw_rdata;
    logic [31:0] sr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpr_bank_file i_fpr_bank_file (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_view(wr_view), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_view(rd_view), .rd_idx(rd_idx), .rd_data(rd_data),
        .mb_we(mb_we), .mb_sel(mb_sel), .mb_val(mb_val),
        .cw_we(cw_we), .cw_wdata(cw_wdata), .cw_rdata(cw_rdata),
        .sr_rdata(sr_rdata)
    );

    // {req[77:74], is_read[73], view[72:70], idx[69:64], data[63:0]}, bank bit = 0
    localparam int NV = 27;
    localparam logic [77:0] VECS [NV] = '{
        {4'd0, 1'b0, 3'd0, 6'd5,  64'h00000000_11111105},
        {4'd2, 1'b1, 3'd0, 6'd5,  64'h00000000_11111105},  // R2 raw
        {4'd0, 1'b0, 3'd1, 6'd3,  64'h00000000_AAAA0003},
        {4'd3, 1'b1, 3'd0, 6'd3,  64'h00000000_AAAA0003},  // R3 current -> 3
        {4'd0, 1'b0, 3'd2, 6'd3,  64'h00000000_BBBB0013},
        {4'd3, 1'b1, 3'd0, 6'd19, 64'h00000000_BBBB0013},  // R3 opposite -> 19
        {4'd0, 1'b0, 3'd3, 6'd10, 64'h01234567_89ABCDEF},
        {4'd4, 1'b1, 3'd0, 6'd10, 64'h00000000_01234567},  // R4 upper half
        {4'd4, 1'b1, 3'd0, 6'd11, 64'h00000000_89ABCDEF},  // R4 lower half
        {4'd4, 1'b1, 3'd3, 6'd10, 64'h01234567_89ABCDEF},  // R4 pair read
        {4'd0, 1'b0, 3'd3, 6'd63, 64'hCAFEF00D_DEADBEEF},
        {4'd4, 1'b1, 3'd0, 6'd0,  64'h00000000_DEADBEEF},  // R4 wrap
        {4'd4, 1'b1, 3'd0, 6'd63, 64'h00000000_CAFEF00D},  // R4
        {4'd0, 1'b0, 3'd6, 6'd19, 64'h00000000_0000C0DE},
        {4'd5, 1'b1, 3'd0, 6'd12, 64'h00000000_0000C0DE},  // R5 vector masked
        {4'd0, 1'b0, 3'd7, 6'd6,  64'h00000000_32323232},
        {4'd5, 1'b1, 3'd0, 6'd32, 64'h00000000_32323232},  // R5 matrix masked
        {4'd5, 1'b1, 3'd6, 6'd3,  64'h00000000_0000C0DE},  // R5
        {4'd5, 1'b1, 3'd7, 6'd2,  64'h00000000_32323232},  // R5
        {4'd0, 1'b0, 3'd1, 6'd20, 64'h00000000_20202020},
        {4'd3, 1'b1, 3'd0, 6'd20, 64'h00000000_20202020},  // R3
        {4'd0, 1'b0, 3'd2, 6'd50, 64'h00000000_02020202},
        {4'd3, 1'b1, 3'd0, 6'd2,  64'h00000000_02020202},  // R3 wrap 66 -> 2
        {4'd0, 1'b0, 3'd5, 6'd24, 64'h40404040_41414141},
        {4'd4, 1'b1, 3'd0, 6'd40, 64'h00000000_40404040},  // R4 opposite pair
        {4'd4, 1'b1, 3'd0, 6'd41, 64'h00000000_41414141},  // R4
        {4'd4, 1'b1, 3'd4, 6'd10, 64'h01234567_89ABCDEF}   // R4 current pair
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [2:0] v, input logic [5:0] i, input logic [63:0] d);
        wr_en = 1'b1; wr_view = v; wr_idx = i; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic [2:0] v, input logic [5:0] i,
                         input logic [63:0] exp);
        rd_view = v; rd_idx = i;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_mb(input logic [2:0] s, input logic val);
        mb_we = 1'b1; mb_sel = s; mb_val = val;
        tick();
        mb_we = 1'b0;
    endtask

    task automatic do_cw(input logic [31:0] d);
        cw_we = 1'b1; cw_wdata = d;
        tick();
        cw_we = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        do_rd("R1", 3'd0, 6'd5, 64'h0);
        chk("R1", {32'h0, sr_rdata}, 64'h0);
        chk("R1", {32'h0, cw_rdata}, 64'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k][73])
                do_rd($sformatf("R%0d", VECS[k][77:74]), VECS[k][72:70], VECS[k][69:64],
                      VECS[k][63:0]);
            else
                do_wr(VECS[k][72:70], VECS[k][69:64], VECS[k][63:0]);
        end

        // R2 same-cycle read of a written entry returns the old value
        wr_en = 1'b1; wr_view = 3'd0; wr_idx = 6'd5; wr_data = 64'h0000FFFF_55555555;
        do_rd("R2", 3'd0, 6'd5, 64'h00000000_11111105);
        tick();
        wr_en = 1'b0;
        do_rd("R2", 3'd0, 6'd5, 64'h00000000_55555555);

        // R9 bank flip and a current-bank write in the same cycle: old bank used
        mb_we = 1'b1; mb_sel = 3'd5; mb_val = 1'b1;
        wr_en = 1'b1; wr_view = 3'd1; wr_idx = 6'd3; wr_data = 64'h0000_0000_33333333;
        tick();
        mb_we = 1'b0; wr_en = 1'b0;
        do_rd("R9", 3'd0, 6'd3, 64'h00000000_33333333);
        chk("R6", {32'h0, sr_rdata}, 64'h4000);

        // R3 / R4 with bank bit = 1
        do_rd("R3", 3'd1, 6'd3, 64'h00000000_BBBB0013);
        do_rd("R3", 3'd2, 6'd3, 64'h00000000_33333333);
        do_rd("R4", 3'd5, 6'd10, 64'h01234567_89ABCDEF);
        do_rd("R4", 3'd4, 6'd47, 64'hCAFEF00D_DEADBEEF);

        // R7 merged read
        chk("R7", {32'h0, cw_rdata}, 64'h0020_0000);

        // R8 combined write
        do_cw(32'h0018_00A5);
        chk("R8", {32'h0, sr_rdata}, 64'h3000);
        chk("R8", {32'h0, cw_rdata}, 64'h0018_00A5);

        // R6 single-bit writes
        do_mb(3'd0, 1'b1);
        do_mb(3'd1, 1'b1);
        do_mb(3'd2, 1'b1);
        chk("R6", {32'h0, sr_rdata}, 64'h3302);
        do_mb(3'd4, 1'b0);
        chk("R6", {32'h0, sr_rdata}, 64'h1302);
        chk("R7", {32'h0, cw_rdata}, 64'h0018_00A5);
        do_mb(3'd6, 1'b1);
        chk("R6", {32'h0, sr_rdata}, 64'h1302);
        do_mb(3'd7, 1'b1);
        chk("R6", {32'h0, sr_rdata}, 64'h1302);

        // R8 combined write overrides a same-cycle PR write
        mb_we = 1'b1; mb_sel = 3'd3; mb_val = 1'b1;
        cw_we = 1'b1; cw_wdata = 32'h0020_0000;
        tick();
        mb_we = 1'b0; cw_we = 1'b0;
        chk("R8", {32'h0, sr_rdata}, 64'h4302);
        chk("R8", {32'h0, cw_rdata}, 64'h0020_0000);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        do_rd("R1", 3'd0, 6'd5, 64'h0);
        do_rd("R1", 3'd3, 6'd63, 64'h0);
        chk("R1", {32'h0, sr_rdata}, 64'h0);
        chk("R1", {32'h0, cw_rdata}, 64'h0);

        done = 1'b1;
        summary();
    end

endmodule